// File: doc/BRIEF.md
# Burst Gain Ramp Profiler

This block shapes the power envelope of a burst transmitter. It scales a stream of complex baseband samples (I and Q) by one gain value drawn from a small gain table. During the start and end of a burst the block steps through that table, so the signal ramps up smoothly instead of switching on with a step, and fades out the same way. The host writes the table through a simple address/data write port. Gains are unsigned fixed-point numbers with one integer bit, so the code with only the top bit set stands for unity.

A table pointer moves once per sample strobe. While the transmit enable is high it counts up to a programmed length and stops there. While the enable is low it counts down to zero and stops there. Ramp-down therefore replays the ramp-up entries in reverse order. Turning profiling off pins the gain at unity and returns the pointer to entry zero. A hold input freezes both the gain and the pointer, so the host can rewrite the table while samples keep flowing.

Top module: `burst_gain_ramp`

## Requirements
- R1: After reset, i_o and q_o are 0, vld_o is 0 and gain_o is 0x800 (unity).
- R2: While prof_en_i is low, the pointer is held at entry 0 and the gain applied at each strobe is 0x800. Samples come out equal to their inputs. When prof_en_i is raised, the profile starts from entry 0.
- R3: While prof_en_i and tx_en_i are high and hold_i is low, each strobe applies table[ptr] and then increments ptr, as long as ptr < len_i. Once ptr reaches len_i it stays there.
- R4: While prof_en_i is high and tx_en_i and hold_i are low, each strobe applies table[ptr] and then decrements ptr, as long as ptr > 0. Once ptr reaches 0 it stays there.
- R5: Both I and Q are scaled by the same gain g, with result = floor((s*g + 1024) / 2048). Here s is the signed 16-bit sample and g is the unsigned 12-bit gain, with bit 11 weighted 1.0 and bit 0 weighted 2^-11.
- R6: A scaled result above 32767 is clamped to 32767, and a result below -32768 is clamped to -32768.
- R7: While hold_i is high, each strobe applies the gain used at the previous strobe and leaves the pointer unchanged. Table writes are accepted during hold and do not change the gain that is applied.
- R8: A table write in the cycle before a strobe, to the entry the pointer selects, is the gain applied at that strobe.
- R9: The outputs i_o and q_o change only in the cycle after a strobe. vld_o is high for exactly that one cycle.
- R10: gain_o shows the gain that was applied to the most recent strobed sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prof_en_i | input | 1 | Profile enable; low forces unity gain and pointer 0 |
| hold_i | input | 1 | Freeze gain and pointer |
| tx_en_i | input | 1 | Transmit enable; high ramps up, low ramps down |
| len_i | input | 7 | Ramp length (final pointer value) |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 7 | Table write address |
| wr_data_i | input | 12 | Table write data |
| stb_i | input | 1 | Sample strobe |
| i_i | input | 16 | I sample in, signed |
| q_i | input | 16 | Q sample in, signed |
| i_o | output | 16 | Scaled I sample |
| q_o | output | 16 | Scaled Q sample |
| vld_o | output | 1 | Output sample valid |
| gain_o | output | 12 | Gain applied to the last sample |

## Verification
The bench drives a full ramp past len_i and back below zero. A pointer without stop conditions would wrap, and the gains read back would jump to the far end of the table. It rewrites the selected entry both under hold and just before a strobe. A design that latched the table output one strobe early would apply the stale value, and one that ignored hold would apply the new value too soon. Gains near 2.0 with full-scale samples catch a missing clamp, which would wrap the sign. Half-LSB products of both signs catch rounding toward zero in place of the specified round-half-up rule.

// File: rtl/burst_gain_pkg.sv
package burst_gain_pkg;
  typedef enum logic [1:0] {
    STEP_KEEP,
    STEP_UP,
    STEP_DOWN,
    STEP_CLR
  } ptr_step_e;
endpackage

// File: rtl/gain_table.sv
module gain_table #(
  parameter int DEPTH  = 128,
  parameter int GAIN_W = 12,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [GAIN_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [GAIN_W-1:0] rd_data_o
);
  logic [GAIN_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ramp_ptr.sv
module ramp_ptr
  import burst_gain_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prof_en_i,
  input  logic              hold_i,
  input  logic              tx_en_i,
  input  logic              stb_i,
  input  logic [ADDR_W-1:0] len_i,
  output logic [ADDR_W-1:0] ptr_o
);
  ptr_step_e step;
  logic [ADDR_W-1:0] ptr_q;

  always_comb begin
    if (!prof_en_i)                      step = STEP_CLR;
    else if (!stb_i || hold_i)           step = STEP_KEEP;
    else if (tx_en_i && ptr_q < len_i)   step = STEP_UP;
    else if (!tx_en_i && ptr_q != '0)    step = STEP_DOWN;
    else                                 step = STEP_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else begin
      unique case (step)
        STEP_UP:   ptr_q <= ptr_q + 1'b1;
        STEP_DOWN: ptr_q <= ptr_q - 1'b1;
        STEP_CLR:  ptr_q <= '0;
        default:   ptr_q <= ptr_q;
      endcase
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/gain_scaler.sv
module gain_scaler #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 12
) (
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic        [GAIN_W-1:0] gain_i,
  output logic signed [DATA_W-1:0] smp_o
);
  localparam int PW   = DATA_W + GAIN_W + 1;
  localparam int FRAC = GAIN_W - 1;
  localparam logic signed [PW-1:0] HI  = PW'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] LO  = -HI - PW'(1);
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (FRAC - 1);

  logic signed [PW-1:0] prod, rnd, shr, clip;

  always_comb begin
    prod = PW'(smp_i) * PW'($signed({1'b0, gain_i}));
    rnd  = prod + RND;
    shr  = rnd >>> FRAC;
    if (shr > HI)      clip = HI;
    else if (shr < LO) clip = LO;
    else               clip = shr;
  end

  assign smp_o = clip[DATA_W-1:0];
endmodule

// File: rtl/burst_gain_ramp.sv
module burst_gain_ramp #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 12,
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANES  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     prof_en_i,
  input  logic                     hold_i,
  input  logic                     tx_en_i,
  input  logic [ADDR_W-1:0]        len_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [GAIN_W-1:0]        wr_data_i,
  input  logic                     stb_i,
  input  logic signed [DATA_W-1:0] i_i,
  input  logic signed [DATA_W-1:0] q_i,
  output logic signed [DATA_W-1:0] i_o,
  output logic signed [DATA_W-1:0] q_o,
  output logic                     vld_o,
  output logic [GAIN_W-1:0]        gain_o
);
  localparam logic [GAIN_W-1:0] GAIN_ONE = {1'b1, {(GAIN_W-1){1'b0}}};

  logic [ADDR_W-1:0] ptr;
  logic [GAIN_W-1:0] tbl_gain, gain_cur, gain_q;
  logic signed [DATA_W-1:0] smp_in  [LANES];
  logic signed [DATA_W-1:0] smp_out [LANES];
  logic signed [DATA_W-1:0] smp_q   [LANES];

  gain_table #(.DEPTH(DEPTH), .GAIN_W(GAIN_W)) u_tbl (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (ptr),
    .rd_data_o (tbl_gain)
  );

  ramp_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prof_en_i (prof_en_i),
    .hold_i    (hold_i),
    .tx_en_i   (tx_en_i),
    .stb_i     (stb_i),
    .len_i     (len_i),
    .ptr_o     (ptr)
  );

  // hold wins over the table and over bypass
  always_comb begin
    if (hold_i)          gain_cur = gain_q;
    else if (prof_en_i)  gain_cur = tbl_gain;
    else                 gain_cur = GAIN_ONE;
  end

  assign smp_in[0] = i_i;
  assign smp_in[1] = q_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    gain_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scl (
      .smp_i  (smp_in[l]),
      .gain_i (gain_cur),
      .smp_o  (smp_out[l])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    smp_q[l] <= '0;
      else if (stb_i) smp_q[l] <= smp_out[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= GAIN_ONE;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= stb_i;
      if (stb_i) gain_q <= gain_cur;
    end
  end

  assign i_o    = smp_q[0];
  assign q_o    = smp_q[1];
  assign gain_o = gain_q;
endmodule

// File: rtl/burst_gain_ramp_chk.sv
module burst_gain_ramp_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int GAIN_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prof_en_i,
  input logic              hold_i,
  input logic              tx_en_i,
  input logic              stb_i,
  input logic [ADDR_W-1:0] len_i,
  input logic [ADDR_W-1:0] ptr,
  input logic [DATA_W-1:0] i_o,
  input logic [DATA_W-1:0] q_o,
  input logic              vld_o,
  input logic [GAIN_W-1:0] gain_o
);
  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prof_en_i |=> ptr == '0); // R2
  AST_BYPASS_UNITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && !prof_en_i && !hold_i |=> gain_o == {1'b1, {(GAIN_W-1){1'b0}}}); // R2
  AST_PTR_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && prof_en_i && !hold_i && tx_en_i && (ptr < len_i)
    |=> ptr == ADDR_W'($past(ptr) + 1'b1)); // R3
  AST_PTR_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && prof_en_i && !hold_i && !tx_en_i && (ptr != '0)
    |=> ptr == ADDR_W'($past(ptr) - 1'b1)); // R4
  AST_HOLD_GAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && hold_i |=> $stable(gain_o)); // R7
  AST_HOLD_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prof_en_i && hold_i |=> $stable(ptr)); // R7
  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> vld_o); // R9
  AST_VLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> !vld_o); // R9
  AST_OUT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(i_o) && $stable(q_o)); // R9
endmodule

bind burst_gain_ramp burst_gain_ramp_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_W(GAIN_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .prof_en_i (prof_en_i),
  .hold_i    (hold_i),
  .tx_en_i   (tx_en_i),
  .stb_i     (stb_i),
  .len_i     (len_i),
  .ptr       (ptr),
  .i_o       (i_o),
  .q_o       (q_o),
  .vld_o     (vld_o),
  .gain_o    (gain_o)
);

// File: tb/burst_gain_ramp_tb.sv
module burst_gain_ramp_tb;
  logic clk = 0, rst_n = 0;
  logic prof_en = 0, hold = 0, tx_en = 0, wr_en = 0, stb = 0;
  logic [6:0] len = 0, wr_addr = 0;
  logic [11:0] wr_data = 0;
  logic signed [15:0] i_in = 0, q_in = 0;
  logic signed [15:0] i_out, q_out;
  logic vld;
  logic [11:0] gain;
  int total = 0, bad = 0;

  always #2 clk = ~clk; // 250 MHz

  burst_gain_ramp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prof_en_i(prof_en), .hold_i(hold),
    .tx_en_i(tx_en), .len_i(len), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .stb_i(stb), .i_i(i_in), .q_i(q_in),
    .i_o(i_out), .q_o(q_out), .vld_o(vld), .gain_o(gain)
  );

  function automatic int exp_scale(input int s, input int g);
    longint p = longint'(s) * longint'(g);
    longint r = (p + 1024) >>> 11;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 7'(a); wr_data = 12'(d);
    @(negedge clk); wr_en = 0;
  endtask

  // one strobe, then check gain and both lanes
  task automatic strobe(input string req, input int si, input int sq, input int g);
    @(negedge clk); stb = 1; i_in = 16'(si); q_in = 16'(sq);
    @(negedge clk); stb = 0;
    chk({req, " gain"}, int'(gain), g);
    chk({req, " i"}, int'(i_out), exp_scale(si, g));
    chk({req, " q"}, int'(q_out), exp_scale(sq, g));
    chk("R9 vld", int'(vld), 1);
  endtask

  task automatic t_reset;
    chk("R1 i", int'(i_out), 0);
    chk("R1 q", int'(q_out), 0);
    chk("R1 vld", int'(vld), 0);
    chk("R1 gain", int'(gain), 'h800);
  endtask

  task automatic t_bypass;
    strobe("R2 bypass", 32767, -32768, 'h800);
    chk("R2 passthru i", int'(i_out), 32767);
    chk("R2 passthru q", int'(q_out), -32768);
  endtask

  task automatic t_ramp;
    for (int k = 0; k < 128; k++) wr(k, k * 32);
    @(negedge clk); prof_en = 1; len = 5; tx_en = 1;
    for (int n = 0; n < 8; n++) strobe("R3 up", 1000, -777, (n < 5 ? n : 5) * 32);
    @(negedge clk); tx_en = 0;
    for (int n = 0; n < 7; n++) strobe("R4 down", -1234, 555, (5 - n > 0 ? 5 - n : 0) * 32);
  endtask

  task automatic t_hold_live;
    @(negedge clk); tx_en = 1;
    for (int n = 0; n < 3; n++) strobe("R3 up2", 400, 400, n * 32);
    @(negedge clk); hold = 1;
    wr(3, 'h555);
    strobe("R7 hold", 3000, -3000, 64);
    strobe("R7 hold2", 3000, -3000, 64);
    @(negedge clk); hold = 0;
    strobe("R7 release", 3000, -3000, 'h555);
    strobe("R7 ptr kept", 3000, -3000, 128);
    wr(5, 'h123); // pointer now at 5 == len
    strobe("R8 live write", 2000, -2000, 'h123);
  endtask

  task automatic t_restart;
    @(negedge clk); prof_en = 0;
    strobe("R2 off", 1111, -2222, 'h800);
    @(negedge clk); prof_en = 1;
    strobe("R2 restart at 0", 1111, -2222, 0);
    strobe("R3 restart step", 1111, -2222, 32);
  endtask

  task automatic t_idle;
    int li, lq;
    li = int'(i_out); lq = int'(q_out);
    repeat (3) @(negedge clk);
    chk("R9 idle vld", int'(vld), 0);
    chk("R9 idle i", int'(i_out), li);
    chk("R9 idle q", int'(q_out), lq);
  endtask

  task automatic t_sat_round;
    @(negedge clk); prof_en = 0; tx_en = 0;
    @(negedge clk); prof_en = 1;
    wr(0, 'hFFF);
    strobe("R6 sat full", 32767, -32768, 'hFFF);
    chk("R6 clamp hi", int'(i_out), 32767);
    chk("R6 clamp lo", int'(q_out), -32768);
    strobe("R6 sat mid", 20000, -20000, 'hFFF);
    wr(0, 'h400);
    strobe("R5 round", 3, -3, 'h400);
    chk("R5 half up pos", int'(i_out), 2);
    chk("R5 half up neg", int'(q_out), -1);
    strobe("R10 gain", -5, 5, 'h400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_bypass();
    t_ramp();
    t_hold_live();
    t_restart();
    t_idle();
    t_sat_round();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule